// File: doc/BRIEF.md
# Four-Rail Timed Power-Up Sequencer

This controller brings up four supply rails in a programmed order and takes them down again in a second programmed order. It watches four rail-good inputs, an enable input and a shared system-kill line. Once everything has been satisfied without a break for a qualification window, it starts four on-delay timers together and raises each rail's gate-enable output when that rail's own delay runs out. When every gate reports fully on, a hold-off period starts. The active-low reset output is released only when that period ends.

Removing enable lowers reset first. Then four off-delay timers start together and each gate drops when its own off-delay runs out. A rail-good input that stays low longer than a glitch window is a fault. A fault drops all gates in the same cycle, holds reset low and pulls the shared kill line low. When any device drives the kill line low from outside, all gates are forced off. Releasing the line while every other input is satisfied starts the on-delays at once, with no qualification window. After a fault or a shutdown, the controller starts again by itself once the gates report low and the inputs are satisfied.

All timing counts pulses of one tick-enable input. The qualification window, glitch window, hold-off and delay unit are parameters given in ticks. The enable polarity is also a parameter. The analog gate drive stays outside the block. It reports back through per-rail "fully on" and "below low threshold" flags.

Top module: `rail_sequencer`

## Requirements
- R1: After reset the gate outputs are all 0, `rst_n_o` is 0 and `sysrst_pull_o` is 0.
- R2: Turn-on timing starts only after QUAL_TICKS consecutive ticks during which all `uv_ok_i` bits are 1, enable is active and `sysrst_in_n_i` is 1. Any break restarts the count. Clock cycles without `tick_i` do not advance it.
- R3: The on-delay of rail i is `on_dly_i[16*i+15:16*i]` in units of UNIT_TICKS ticks, and all four timers start together. Gate i goes high d_i*UNIT_TICKS ticks after qualification ends. A zero value raises it in the cycle that follows.
- R4: `rst_n_o` goes high HOLD_TICKS ticks after all gates are on and all `gate_full_i` bits are 1. If any `gate_full_i` bit drops during that period, the period starts over.
- R5: A `uv_ok_i` bit that is low for fewer than GLITCH_TICKS consecutive ticks has no effect. Once it has been low for GLITCH_TICKS ticks, all gates clear in the same cycle and `rst_n_o` goes low. `sysrst_pull_o` then stays 1 until every `uv_ok_i` bit is 1 and every `gate_low_i` bit is 1.
- R6: When enable goes inactive, `rst_n_o` goes low in the next cycle and the off-delays (`off_dly_i`, same layout and unit as R3) start together. Gate i clears d_i*UNIT_TICKS ticks later. A zero value clears it in the cycle after `rst_n_o` goes low.
- R7: While `sysrst_in_n_i` is low, all gates are off and `rst_n_o` is low, and `sysrst_pull_o` stays 0. If the line rises while enable is active and all `uv_ok_i` are 1, the on-delays start in that cycle with no qualification window.
- R8: After a fault or a shutdown, turn-on restarts automatically through the full qualification window, but only once the gates report low and all inputs are satisfied. The release of the block's own kill pull does not skip the window.
- R9: A fault during the turn-off ramp clears all remaining gates at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Time-base strobe; all timers count these pulses |
| en_i | input | 1 | Enable; active level set by EN_ACTIVE_HIGH |
| uv_ok_i | input | NRAIL | Per-rail undervoltage-okay flags |
| on_dly_i | input | NRAIL*DLY_W | Packed per-rail on-delays |
| off_dly_i | input | NRAIL*DLY_W | Packed per-rail off-delays |
| gate_full_i | input | NRAIL | Per-rail gate fully-on flags |
| gate_low_i | input | NRAIL | Per-rail gate below-low-threshold flags |
| sysrst_in_n_i | input | 1 | Observed level of the shared kill line |
| gate_on_o | output | NRAIL | Per-rail gate enables |
| rst_n_o | output | 1 | Active-low system reset output |
| sysrst_pull_o | output | 1 | 1 pulls the shared kill line low |

## Verification
The bench measures the exact cycle in which each gate and reset edge appears, over several delay sets: mixed orders, equal delays and zero delays. A timer that starts one cycle late or loads the wrong packed field shows up as a shifted edge. It breaks the qualification window and stalls the tick to show that the count restarts and freezes. It also drops a fully-on flag during the hold-off, so a design that keeps counting releases reset early. It drives rail-good pulses that are one tick shorter than the glitch window and pulses that reach it, to catch a filter that is off by one. It also checks that a fault in the middle of the turn-off ramp clears the remaining gates at once, and that a design whose own kill release counts as an external release restarts too soon.

// File: rtl/rseq_pkg.sv
// Shared types for the four-rail sequencer.
package rseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // gates off, qualifying inputs
        ST_UP   = 3'd1,   // on-delays running
        ST_HOLD = 3'd2,   // all gates full, reset hold-off running
        ST_RUN  = 3'd3,   // reset released
        ST_DOWN = 3'd4,   // off-delays running
        ST_SHUT = 3'd5    // forced off by fault or kill line
    } seq_state_t;
endpackage

// File: rtl/rseq_span_counter.sv
// Counts strobes while not cleared and flags the strobe that completes LIMIT
// consecutive counts. Assumes LIMIT >= 1; the owner clears it once done.
module rseq_span_counter #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic count_i,
    output logic done_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign done_o = count_i && !clear_i && (cnt_q == LAST);

    // Advance on each strobe, saturate at the last value, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (count_i && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: without a strobe or clear the count must not move
    span_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !count_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rseq_tick_div.sv
// Divides the tick strobe by UNIT_TICKS to give the delay-unit strobe.
// Restart realigns the phase so every timer load sees full units.
module rseq_tick_div #(
    parameter int UNIT_TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic restart_i,
    output logic unit_o
);
    localparam int CW = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(UNIT_TICKS - 1);

    logic [CW-1:0] cnt_q;

    assign unit_o = tick_i && (cnt_q == LAST);

    // Wrap the tick count every UNIT_TICKS ticks; restart zeroes the phase.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rseq_rail_timer.sv
// One rail's delay timer. Loads a delay in units, counts it down on unit
// strobes while running, and reports expiry until running stops.
module rseq_rail_timer #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DLY_W-1:0] dly_i,
    input  logic             run_i,
    input  logic             unit_i,
    output logic             expired_o
);
    logic [DLY_W-1:0] rem_q;
    logic             armed_q;

    assign expired_o = run_i && armed_q && (rem_q == '0);

    // Load on request, otherwise count down one unit per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q   <= '0;
            armed_q <= 1'b0;
        end else if (load_i) begin
            rem_q   <= dly_i;
            armed_q <= 1'b1;
        end else if (!run_i) begin
            armed_q <= 1'b0;
        end else if (unit_i && rem_q != '0) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    // R3: between loads the remaining delay never grows
    rem_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (rem_q <= $past(rem_q)));
endmodule

// File: rtl/rail_sequencer.sv
// Four-rail timed power sequencer. Qualifies rail-good, enable and the
// kill line, ramps gates up by per-rail delays, releases reset after a
// hold-off, ramps down by per-rail delays, and forces all gates off on a
// filtered undervoltage fault or an external kill. Assumes gate status
// flags come back from the analog drive and the kill line is wired-AND.
module rail_sequencer
    import rseq_pkg::*;
#(
    parameter int NRAIL          = 4,
    parameter int DLY_W          = 16,
    parameter int QUAL_TICKS     = 10000,
    parameter int HOLD_TICKS     = 160000,
    parameter int GLITCH_TICKS   = 30,
    parameter int UNIT_TICKS     = 1000,
    parameter bit EN_ACTIVE_HIGH = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_i,
    input  logic                   en_i,
    input  logic [NRAIL-1:0]       uv_ok_i,
    input  logic [NRAIL*DLY_W-1:0] on_dly_i,
    input  logic [NRAIL*DLY_W-1:0] off_dly_i,
    input  logic [NRAIL-1:0]       gate_full_i,
    input  logic [NRAIL-1:0]       gate_low_i,
    input  logic                   sysrst_in_n_i,
    output logic [NRAIL-1:0]       gate_on_o,
    output logic                   rst_n_o,
    output logic                   sysrst_pull_o
);
    seq_state_t       state_q, nxt;
    logic [NRAIL-1:0] gate_q;
    logic [NRAIL-1:0] expired;
    logic             rst_q, pull_q, skip_q;
    logic             en_act, uv_all, inputs_ok, active;
    logic             qual_done, hold_done, glitch_fault;
    logic             enter_up, enter_dn, tmr_load, unit;

    assign en_act    = EN_ACTIVE_HIGH ? en_i : !en_i;
    assign uv_all    = &uv_ok_i;
    assign inputs_ok = uv_all && en_act && sysrst_in_n_i;
    assign active    = (state_q == ST_UP) || (state_q == ST_HOLD) ||
                       (state_q == ST_RUN) || (state_q == ST_DOWN);

    // Qualification window: consecutive satisfied ticks while idle.
    rseq_span_counter #(.LIMIT(QUAL_TICKS)) u_qual (
        .clk(clk), .rst_n(rst_n),
        .clear_i(!(state_q == ST_IDLE && inputs_ok)),
        .count_i(tick_i), .done_o(qual_done));

    // Reset hold-off after every gate reports full.
    rseq_span_counter #(.LIMIT(HOLD_TICKS)) u_hold (
        .clk(clk), .rst_n(rst_n),
        .clear_i(state_q != ST_HOLD),
        .count_i(tick_i), .done_o(hold_done));

    // Undervoltage glitch filter while any gate may be on.
    rseq_span_counter #(.LIMIT(GLITCH_TICKS)) u_glitch (
        .clk(clk), .rst_n(rst_n),
        .clear_i(!(active && !uv_all)),
        .count_i(tick_i), .done_o(glitch_fault));

    // Next-state selection; kill has priority over fault, fault over disable.
    always_comb begin
        nxt = state_q;
        case (state_q)
            ST_IDLE: begin
                if (skip_q && sysrst_in_n_i && uv_all && en_act) nxt = ST_UP;
                else if (qual_done)                              nxt = ST_UP;
            end
            ST_UP, ST_HOLD, ST_RUN, ST_DOWN: begin
                if (!sysrst_in_n_i)                    nxt = ST_SHUT;
                else if (glitch_fault)                 nxt = ST_SHUT;
                else if (state_q != ST_DOWN && !en_act) nxt = ST_DOWN;
                else if (state_q == ST_UP) begin
                    if ((&gate_q) && (&gate_full_i))   nxt = ST_HOLD;
                end else if (state_q == ST_HOLD) begin
                    if (!(&gate_full_i))               nxt = ST_UP;
                    else if (hold_done)                nxt = ST_RUN;
                end else if (state_q == ST_DOWN) begin
                    if (gate_q == '0 && (&gate_low_i)) nxt = ST_IDLE;
                end
            end
            ST_SHUT: begin
                if ((&gate_low_i) && (!pull_q || uv_all)) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign enter_up = (state_q == ST_IDLE) && (nxt == ST_UP);
    assign enter_dn = (state_q != ST_DOWN) && (nxt == ST_DOWN);
    assign tmr_load = enter_up || enter_dn;

    // Delay-unit strobe, realigned at every timer load.
    rseq_tick_div #(.UNIT_TICKS(UNIT_TICKS)) u_div (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .restart_i(tmr_load), .unit_o(unit));

    // One delay timer per rail; the entered ramp picks on or off delay.
    for (genvar g = 0; g < NRAIL; g++) begin : g_rail
        logic [DLY_W-1:0] dly_sel;
        assign dly_sel = enter_dn ? off_dly_i[g*DLY_W +: DLY_W]
                                  : on_dly_i[g*DLY_W +: DLY_W];
        rseq_rail_timer #(.DLY_W(DLY_W)) u_tmr (
            .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .dly_i(dly_sel),
            .run_i(active), .unit_i(unit), .expired_o(expired[g]));
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nxt;
    end

    // Gate enables: set on ramp-up expiry, cleared on ramp-down or at once.
    always_ff @(posedge clk) begin
        if (!rst_n || nxt == ST_SHUT) begin
            gate_q <= '0;
        end else if (state_q == ST_UP && nxt != ST_DOWN) begin
            gate_q <= gate_q | expired;
        end else if (state_q == ST_DOWN) begin
            gate_q <= gate_q & ~expired;
        end
    end

    // Reset output, kill-line pull and kill-release memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_q  <= 1'b0;
            pull_q <= 1'b0;
            skip_q <= 1'b0;
        end else begin
            rst_q  <= (nxt == ST_RUN);
            pull_q <= (nxt == ST_SHUT) && (glitch_fault || pull_q);
            skip_q <= (state_q == ST_IDLE) && (nxt == ST_IDLE) && !sysrst_in_n_i;
        end
    end

    assign gate_on_o     = gate_q;
    assign rst_n_o       = rst_q;
    assign sysrst_pull_o = pull_q;

    // R4
    rst_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n_o |-> (&gate_on_o));
    // R5
    pull_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sysrst_pull_o |-> (gate_on_o == '0));
    // R6
    gate_fall_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n_o |=> (!rst_n_o || gate_on_o == $past(gate_on_o)));
    // R3
    ramp_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UP) |=> (state_q != ST_UP) ||
                               ((gate_q & $past(gate_q)) == $past(gate_q)));
    // R7
    kill_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sysrst_in_n_i |=> (gate_on_o == '0 && !rst_n_o));
endmodule

// File: tb/rail_sequencer_test.sv
module rail_sequencer_test;
    localparam int PERIOD = 10;
    localparam int QUAL   = 20;
    localparam int HOLD   = 15;
    localparam int GLT    = 4;
    localparam int UNIT   = 2;
    localparam int WATCHDOG = 150000;
    // Per vector: on delays rail0..3, then off delays rail0..3
    localparam int VEC [4][8] = '{
        '{0, 3, 6, 9,   9, 6, 3, 0},
        '{5, 5, 5, 5,   0, 0, 0, 0},
        '{7, 0, 2, 1,   1, 4, 0, 2},
        '{1, 2, 3, 4,   4, 3, 2, 1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        en = 1'b0;
    logic [3:0]  uv = 4'hF;
    logic        ext_n = 1'b1;
    logic [3:0]  full_mask = 4'hF;
    logic [63:0] on_dly = '0;
    logic [63:0] off_dly = '0;
    logic [3:0]  gate_on;
    logic        rst_out_n, pull;
    wire  [3:0]  gate_full = gate_on & full_mask;
    wire  [3:0]  gate_low  = ~gate_on;
    wire         sysrst_line = ext_n & ~pull;

    int cyc = 0;
    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    int rise [4];
    int fall [4];
    int rst_rise, rst_fall;
    logic [3:0] prev_g = '0;
    logic       prev_r = 1'b0;

    rail_sequencer #(
        .NRAIL(4), .DLY_W(16), .QUAL_TICKS(QUAL), .HOLD_TICKS(HOLD),
        .GLITCH_TICKS(GLT), .UNIT_TICKS(UNIT), .EN_ACTIVE_HIGH(1'b1)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_i(en), .uv_ok_i(uv),
        .on_dly_i(on_dly), .off_dly_i(off_dly), .gate_full_i(gate_full),
        .gate_low_i(gate_low), .sysrst_in_n_i(sysrst_line),
        .gate_on_o(gate_on), .rst_n_o(rst_out_n), .sysrst_pull_o(pull));

    always #(PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Edge recorder: cycle number of the last rise and fall of each output.
    always @(negedge clk) begin
        for (int c = 0; c < 4; c++) begin
            if (gate_on[c] && !prev_g[c]) rise[c] = cyc;
            if (!gate_on[c] && prev_g[c]) fall[c] = cyc;
        end
        if (rst_out_n && !prev_r) rst_rise = cyc;
        if (!rst_out_n && prev_r) rst_fall = cyc;
        prev_g = gate_on;
        prev_r = rst_out_n;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_mon();
        for (int c = 0; c < 4; c++) begin
            rise[c] = -1;
            fall[c] = -1;
        end
        rst_rise = -1;
        rst_fall = -1;
    endtask

    task automatic set_dly(input int a0, input int a1, input int a2, input int a3,
                           input int b0, input int b1, input int b2, input int b3);
        on_dly  = {16'(a3), 16'(a2), 16'(a1), 16'(a0)};
        off_dly = {16'(b3), 16'(b2), 16'(b1), 16'(b0)};
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got %0d expected 0 cycles left", WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int t0, t1, t2, t3, t4, t5, t6, t7, mx, mxo;
        clr_mon();
        step(5);
        rst_n = 1'b1;
        step(3);
        // R1 reset state
        chk("R1", "gates after reset", int'(gate_on), 0);
        chk("R1", "rst_n_o after reset", int'(rst_out_n), 0);
        chk("R1", "pull after reset", int'(pull), 0);

        // Vector table: ordered ramp up (R3, R4) then ramp down (R6)
        for (int v = 0; v < 4; v++) begin
            set_dly(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3],
                    VEC[v][4], VEC[v][5], VEC[v][6], VEC[v][7]);
            mx = 0;
            mxo = 0;
            for (int c = 0; c < 4; c++) begin
                if (VEC[v][c] > mx) mx = VEC[v][c];
                if (VEC[v][4+c] > mxo) mxo = VEC[v][4+c];
            end
            clr_mon();
            en = 1'b1;
            t0 = cyc;
            step(QUAL + 2*mx + HOLD + 8);
            for (int c = 0; c < 4; c++)
                chk("R3", $sformatf("vec%0d gate%0d rise", v, c), rise[c],
                    t0 + QUAL + 2*VEC[v][c] + 1);
            chk("R4", $sformatf("vec%0d reset release", v), rst_rise,
                t0 + QUAL + 2*mx + 1 + 1 + HOLD);
            en = 1'b0;
            t1 = cyc;
            step(2*mxo + 8);
            chk("R6", $sformatf("vec%0d reset drop", v), rst_fall, t1 + 1);
            for (int c = 0; c < 4; c++)
                chk("R6", $sformatf("vec%0d gate%0d fall", v, c), fall[c],
                    t1 + 2*VEC[v][4+c] + 2);
        end

        // R2: a one-cycle break in qualification restarts the window
        set_dly(0, 0, 0, 0, 0, 0, 0, 0);
        clr_mon();
        en = 1'b1;
        t0 = cyc;
        step(QUAL - 3);
        uv[1] = 1'b0;
        step(1);
        uv[1] = 1'b1;
        t1 = cyc;
        step(QUAL + 6);
        chk("R2", "rise after broken window", rise[0], t1 + QUAL + 1);
        en = 1'b0;
        step(8);

        // R2: stalled tick freezes the qualification count
        clr_mon();
        en = 1'b1;
        t0 = cyc;
        step(5);
        tick = 1'b0;
        step(30);
        tick = 1'b1;
        step(QUAL + 6);
        chk("R2", "rise with stalled tick", rise[0], t0 + QUAL + 31);
        en = 1'b0;
        step(8);

        // R4: a fully-on flag dropping in the hold-off restarts it
        set_dly(1, 2, 3, 4, 0, 0, 0, 0);
        clr_mon();
        en = 1'b1;
        t0 = cyc;
        step(QUAL + 8 + 1 + 3);
        full_mask[2] = 1'b0;
        step(3);
        full_mask[2] = 1'b1;
        t2 = cyc;
        step(HOLD + 5);
        chk("R4", "release after hold restart", rst_rise, t2 + 1 + HOLD);

        // R5: a low pulse one tick short of the glitch window is ignored
        uv[2] = 1'b0;
        step(GLT - 1);
        uv[2] = 1'b1;
        step(2);
        chk("R5", "short glitch keeps reset", int'(rst_out_n), 1);
        chk("R5", "short glitch keeps gates", int'(gate_on), 15);

        // R5: a pulse reaching the window is a fault
        uv[2] = 1'b0;
        t3 = cyc;
        step(GLT - 1);
        chk("R5", "gates just before fault", int'(gate_on), 15);
        step(1);
        chk("R5", "gates on fault", int'(gate_on), 0);
        chk("R5", "reset on fault", int'(rst_out_n), 0);
        chk("R5", "pull on fault", int'(pull), 1);
        step(5);
        chk("R5", "pull held while rail low", int'(pull), 1);
        clr_mon();
        uv[2] = 1'b1;
        t4 = cyc;
        step(1);
        chk("R5", "pull released", int'(pull), 0);
        step(QUAL + HOLD + 20);
        chk("R8", "auto restart gate0", rise[0], t4 + QUAL + 4);
        chk("R8", "auto restart gate3", rise[3], t4 + QUAL + 10);

        // R7: external kill forces off without pulling, release skips window
        ext_n = 1'b0;
        step(1);
        chk("R7", "kill gates", int'(gate_on), 0);
        chk("R7", "kill reset", int'(rst_out_n), 0);
        chk("R7", "kill no pull", int'(pull), 0);
        step(QUAL + 10);
        chk("R7", "gates held off by kill", int'(gate_on), 0);
        clr_mon();
        ext_n = 1'b1;
        t6 = cyc;
        step(15);
        chk("R7", "no-wait gate0", rise[0], t6 + 4);
        chk("R7", "no-wait gate3", rise[3], t6 + 10);
        step(HOLD + 5);
        chk("R7", "reset after no-wait start", int'(rst_out_n), 1);

        // R9: fault during ramp-down clears remaining gates together
        set_dly(1, 2, 3, 4, 0, 5, 10, 15);
        en = 1'b0;
        t7 = cyc;
        step(3);
        uv[0] = 1'b0;
        step(GLT - 1);
        chk("R9", "gates before ramp fault", int'(gate_on), 14);
        step(1);
        chk("R9", "gates after ramp fault", int'(gate_on), 0);
        chk("R9", "pull after ramp fault", int'(pull), 1);
        uv[0] = 1'b1;
        step(QUAL + 10);
        chk("R8", "no restart while disabled", int'(gate_on), 0);
        chk("R8", "reset low while disabled", int'(rst_out_n), 0);
        chk("R8", "pull cleared", int'(pull), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule